// File: doc/BRIEF.md
# Group-Address Hash Filter for Ethernet Receive

This block decides, for each received frame, whether its destination MAC address should be kept. The six destination bytes arrive one per valid cycle, the first marked by a start strobe. While they arrive the block folds them into a CRC-32 and captures them. Once the sixth byte has been taken, it issues one accept or reject decision.

Addresses with the group bit set are judged by a 64-entry hash table. The entry is picked by the top six bits of the CRC. The broadcast address is always kept. Every other address is kept only when it equals the programmed station address exactly.

The hash table and the station address are plain level inputs, supplied by the surrounding MAC. The block has no storage visible to software.

Top module: `mcast_hash_filter`

## Requirements
- R1: The CRC starts at 0xFFFFFFFF and processes each byte least significant bit first, shifting right. When the bit leaving the register is 1 it is XORed with 0xEDB88320. It covers the six address bytes in arrival order. `hash_index` equals bits 31..26 of the final register, not inverted.
- R2: For a group address that is not broadcast, `accept` equals the table bit chosen by `hash_index`. Indices 0..31 select bit `hash_index` of `hash_lo`. Indices 32..63 select bit `hash_index-32` of `hash_hi`.
- R3: With `hash_lo` and `hash_hi` both zero, every group address other than broadcast is rejected.
- R4: The address FF:FF:FF:FF:FF:FF is accepted whatever the table holds.
- R5: `group_hit` is bit 0 of the first address byte. An address without that bit is accepted only when all six bytes equal the station address. The station bytes are laid out as follows:
  - bytes 0..3 are `sta_lo[31:24]`, `[23:16]`, `[15:8]`, `[7:0]`;
  - bytes 4 and 5 are `sta_hi[31:24]` and `sta_hi[23:16]`;
  - `sta_hi[15:0]` is ignored.
- R6: The sixth byte is sampled on some rising edge. `decision_valid` is then high for exactly one cycle, starting with the following rising edge. It carries `accept`, `group_hit` and `hash_index`. Outside that cycle these outputs are 0.
- R7: Cycles with `byte_valid` low are skipped and do not count as bytes. Bytes after the sixth are ignored until the next start strobe and produce no decision.
- R8: A start strobe arriving with a byte restarts capture with that byte as byte 0. Any partially captured address is abandoned.
- R9: While `rst` is high, and in the cycle after it, `decision_valid` and `accept` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_valid | input | 1 | `rx_byte` carries an address byte this cycle |
| addr_start | input | 1 | With `byte_valid`: this byte is address byte 0 |
| rx_byte | input | 8 | Address byte, arrival order |
| sta_lo | input | 32 | Station address bytes 0..3, byte 0 in the top bits |
| sta_hi | input | 32 | Station address bytes 4..5 in the top half |
| hash_lo | input | 32 | Hash table entries 0..31 |
| hash_hi | input | 32 | Hash table entries 32..63 |
| decision_valid | output | 1 | One-cycle decision strobe |
| accept | output | 1 | Frame kept |
| group_hit | output | 1 | Address was a group address |
| hash_index | output | 6 | Table index derived from the CRC |

## Verification
The following are checked by assertions on every cycle:
- the decision strobe is a single-cycle pulse;
- all outputs are quiet between decisions and after reset;
- a non-broadcast group decision matches the table bit at `hash_index`, as the table stood when the decision was formed;
- an all-zero table rejects every non-broadcast group address.

Other behaviour can only be shown by the bench's scenarios against its cycle-by-cycle model:
- that the CRC and the index are correct;
- the station comparison, including the ignored low half of `sta_hi`;
- the position of the strobe relative to gapped byte streams;
- that trailing bytes are ignored;
- restarts in mid-address.

// File: rtl/mhf_pkg.sv
package mhf_pkg;
  localparam int unsigned ADDR_BYTES = 6;
  localparam int unsigned CRC_W      = 32;
  localparam int unsigned IDX_W      = 6;
  localparam int unsigned TABLE_W    = 1 << IDX_W;
  localparam logic [CRC_W-1:0] CRC_PRESET = 32'hFFFF_FFFF;
  localparam logic [CRC_W-1:0] CRC_POLY_R = 32'hEDB8_8320;

  typedef logic [IDX_W-1:0] hidx_t;

  // One byte of a right-shifting CRC, low bit of the byte enters first.
  function automatic logic [CRC_W-1:0] crc_fold(input logic [CRC_W-1:0] c_in,
                                                input logic [7:0] d);
    logic [CRC_W-1:0] c;
    c = c_in ^ {{(CRC_W-8){1'b0}}, d};
    for (int b = 0; b < 8; b++) begin
      if (c[0]) c = (c >> 1) ^ CRC_POLY_R;
      else      c = c >> 1;
    end
    return c;
  endfunction
endpackage

// File: rtl/mhf_crc_unit.sv
module mhf_crc_unit
  import mhf_pkg::*;
#(
  parameter int unsigned W = CRC_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         restart,
  input  logic         advance,
  input  logic [7:0]   din,
  output logic [W-1:0] crc_q
);
  logic [W-1:0] seed;

  // A restart folds the byte into the preset, not into the running value.
  assign seed = restart ? CRC_PRESET : crc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      crc_q <= CRC_PRESET;
    end else if (restart || advance) begin
      crc_q <= crc_fold(seed, din);
    end
  end
endmodule

// File: rtl/mhf_addr_capture.sv
module mhf_addr_capture #(
  parameter int unsigned NB = 6,
  localparam int unsigned CW = $clog2(NB + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            byte_valid,
  input  logic            addr_start,
  input  logic [7:0]      rx_byte,
  output logic            restart,
  output logic            advance,
  output logic            done_q,
  output logic [NB*8-1:0] addr_q
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] pos;
  logic          take;

  localparam logic [CW-1:0] LAST = CW'(NB - 1);
  localparam logic [CW-1:0] FULL = CW'(NB);

  // cnt_q == 0: idle before any start; cnt_q == FULL: address complete.
  assign restart = byte_valid && addr_start;
  assign advance = byte_valid && !addr_start && (cnt_q != '0) && (cnt_q != FULL);
  assign take    = restart || advance;
  assign pos     = restart ? '0 : cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= take && (pos == LAST);
      if (take) cnt_q <= pos + 1'b1;
    end
  end

  for (genvar i = 0; i < NB; i++) begin : g_byte
    always_ff @(posedge clk) begin
      if (rst) begin
        addr_q[i*8 +: 8] <= '0;
      end else if (take && (pos == CW'(i))) begin
        addr_q[i*8 +: 8] <= rx_byte;
      end
    end
  end
endmodule

// File: rtl/mhf_classify.sv
module mhf_classify #(
  parameter int unsigned NB = 6
) (
  input  logic [NB*8-1:0] addr_q,
  input  logic [31:0]     sta_lo,
  input  logic [31:0]     sta_hi,
  output logic            is_group,
  output logic            is_bcast,
  output logic            sta_equal
);
  logic [63:0]   sta_all;
  logic [NB-1:0] eq;
  logic [NB-1:0] ones;

  assign sta_all = {sta_lo, sta_hi};

  for (genvar i = 0; i < NB; i++) begin : g_cmp
    assign eq[i]   = addr_q[i*8 +: 8] == sta_all[63 - 8*i -: 8];
    assign ones[i] = &addr_q[i*8 +: 8];
  end

  assign is_group  = addr_q[0];
  assign is_bcast  = &ones;
  assign sta_equal = &eq;
endmodule

// File: rtl/mhf_decide.sv
module mhf_decide
  import mhf_pkg::*;
#(
  parameter int unsigned IW = IDX_W,
  parameter int unsigned CWID = CRC_W,
  localparam int unsigned TW = 1 << IW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            done,
  input  logic [CWID-1:0] crc,
  input  logic            is_group,
  input  logic            is_bcast,
  input  logic            sta_equal,
  input  logic [TW-1:0]   table_bits,
  output logic            valid_q,
  output logic            accept_q,
  output logic            group_q,
  output logic            bcast_q,
  output logic [IW-1:0]   idx_q
);
  logic [IW-1:0] idx;
  logic          tbit;
  logic          keep;

  assign idx  = crc[CWID-1 -: IW];
  assign tbit = table_bits[idx];
  assign keep = is_bcast || (is_group ? tbit : sta_equal);

  always_ff @(posedge clk) begin
    if (rst || !done) begin
      valid_q  <= 1'b0;
      accept_q <= 1'b0;
      group_q  <= 1'b0;
      bcast_q  <= 1'b0;
      idx_q    <= '0;
    end else begin
      valid_q  <= 1'b1;
      accept_q <= keep;
      group_q  <= is_group;
      bcast_q  <= is_bcast;
      idx_q    <= idx;
    end
  end
endmodule

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter
  import mhf_pkg::*;
#(
  parameter int unsigned NB = ADDR_BYTES,
  parameter int unsigned IW = IDX_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          byte_valid,
  input  logic          addr_start,
  input  logic [7:0]    rx_byte,
  input  logic [31:0]   sta_lo,
  input  logic [31:0]   sta_hi,
  input  logic [31:0]   hash_lo,
  input  logic [31:0]   hash_hi,
  output logic          decision_valid,
  output logic          accept,
  output logic          group_hit,
  output logic [IW-1:0] hash_index
);
  logic            restart;
  logic            advance;
  logic            done;
  logic [NB*8-1:0] addr_q;
  logic [CRC_W-1:0] crc_q;
  logic            is_group;
  logic            is_bcast;
  logic            sta_equal;
  logic            dec_bcast;

  mhf_addr_capture #(.NB(NB)) u_cap (
    .clk(clk), .rst(rst), .byte_valid(byte_valid), .addr_start(addr_start),
    .rx_byte(rx_byte), .restart(restart), .advance(advance),
    .done_q(done), .addr_q(addr_q)
  );

  mhf_crc_unit #(.W(CRC_W)) u_crc (
    .clk(clk), .rst(rst), .restart(restart), .advance(advance),
    .din(rx_byte), .crc_q(crc_q)
  );

  mhf_classify #(.NB(NB)) u_cls (
    .addr_q(addr_q), .sta_lo(sta_lo), .sta_hi(sta_hi),
    .is_group(is_group), .is_bcast(is_bcast), .sta_equal(sta_equal)
  );

  mhf_decide #(.IW(IW), .CWID(CRC_W)) u_dec (
    .clk(clk), .rst(rst), .done(done), .crc(crc_q),
    .is_group(is_group), .is_bcast(is_bcast), .sta_equal(sta_equal),
    .table_bits({hash_hi, hash_lo}),
    .valid_q(decision_valid), .accept_q(accept), .group_q(group_hit),
    .bcast_q(dec_bcast), .idx_q(hash_index)
  );
endmodule

// File: rtl/mhf_checker.sv
module mhf_checker #(
  parameter int unsigned IW = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          decision_valid,
  input logic          accept,
  input logic          group_hit,
  input logic [IW-1:0] hash_index,
  input logic [31:0]   hash_lo,
  input logic [31:0]   hash_hi,
  input logic          dec_bcast
);
  logic [63:0] tbl_prev;

  always_ff @(posedge clk) tbl_prev <= {hash_hi, hash_lo};

  p_reset_quiet_r9: assert property (@(posedge clk)
    rst |=> (!decision_valid && !accept));

  p_single_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    decision_valid |=> !decision_valid);

  p_idle_zero_r6: assert property (@(posedge clk) disable iff (rst)
    !decision_valid |-> (!accept && !group_hit && hash_index == '0));

  p_table_lookup_r2: assert property (@(posedge clk) disable iff (rst)
    (decision_valid && group_hit && !dec_bcast) |-> (accept == tbl_prev[hash_index]));

  p_empty_table_r3: assert property (@(posedge clk) disable iff (rst)
    (decision_valid && group_hit && !dec_bcast && tbl_prev == 64'd0) |-> !accept);
endmodule

bind mcast_hash_filter mhf_checker #(.IW(IW)) u_mhf_chk (
  .clk(clk), .rst(rst), .decision_valid(decision_valid), .accept(accept),
  .group_hit(group_hit), .hash_index(hash_index), .hash_lo(hash_lo),
  .hash_hi(hash_hi), .dec_bcast(dec_bcast)
);

// File: tb/test_mcast_hash_filter.sv
module test_mcast_hash_filter;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic byte_valid = 1'b0, addr_start = 1'b0;
  logic [7:0] rx_byte = '0;
  logic [31:0] sta_lo = '0, sta_hi = '0, hash_lo = '0, hash_hi = '0;
  logic decision_valid, accept, group_hit;
  logic [5:0] hash_index;

  always #10 clk = ~clk;

  mcast_hash_filter i_mcast_hash_filter (
    .clk(clk), .rst(rst), .byte_valid(byte_valid), .addr_start(addr_start),
    .rx_byte(rx_byte), .sta_lo(sta_lo), .sta_hi(sta_hi), .hash_lo(hash_lo),
    .hash_hi(hash_hi), .decision_valid(decision_valid), .accept(accept),
    .group_hit(group_hit), .hash_index(hash_index)
  );

  int n_checks = 0, n_fail = 0;
  int edge_no = 0;
  string cur_tag = "R5";

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (edge %0d)", tag, act, exp, edge_no);
    end
  endtask

  function automatic logic [31:0] ref_crc(logic [47:0] a);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = 0; i < 6; i++) begin
      c ^= {24'd0, a[47-8*i -: 8]};
      for (int j = 0; j < 8; j++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
    end
    return c;
  endfunction

  function automatic logic [5:0] ref_idx(logic [47:0] a);
    logic [31:0] c = ref_crc(a);
    return c[31:26];
  endfunction

  // behavioural model
  int m_cnt = 0;
  logic [47:0] m_addr;
  int    q_due[$];
  logic  q_acc[$];
  logic  q_grp[$];
  logic [5:0] q_idx[$];
  string q_tag[$];

  always @(posedge clk) begin
    edge_no++;
    if (rst) begin
      m_cnt = 0;
      q_due.delete(); q_acc.delete(); q_grp.delete(); q_idx.delete(); q_tag.delete();
    end else if (byte_valid) begin
      if (addr_start) begin
        m_addr = '0; m_addr[47:40] = rx_byte; m_cnt = 1;
      end else if (m_cnt >= 1 && m_cnt <= 5) begin
        m_addr[47-8*m_cnt -: 8] = rx_byte; m_cnt++;
      end
      if (m_cnt == 6 && (addr_start || m_cnt == 6)) begin
        logic grp, bc, eq, tb;
        logic [5:0] ix;
        logic [63:0] tbl;
        grp = m_addr[40];
        bc  = (m_addr == 48'hFFFF_FFFF_FFFF);
        eq  = (m_addr == {sta_lo, sta_hi[31:16]});
        ix  = ref_idx(m_addr);
        tbl = {hash_hi, hash_lo};
        tb  = tbl[ix];
        q_due.push_back(edge_no + 1);
        q_acc.push_back(bc ? 1'b1 : (grp ? tb : eq));
        q_grp.push_back(grp);
        q_idx.push_back(ix);
        q_tag.push_back(cur_tag);
        m_cnt = 7;
      end
    end
  end

  always @(negedge clk) begin
    if (edge_no >= 1) begin
      if (q_due.size() > 0 && q_due[0] == edge_no) begin
        chk("R6 strobe", decision_valid, 1);
        chk({q_tag[0], " accept"}, accept, q_acc[0]);
        chk("R5 group flag", group_hit, q_grp[0]);
        chk("R1 index", hash_index, q_idx[0]);
        void'(q_due.pop_front()); void'(q_acc.pop_front()); void'(q_grp.pop_front());
        void'(q_idx.pop_front()); void'(q_tag.pop_front());
      end else begin
        chk("R6/R7 no strobe", decision_valid, 0);
        chk("R6 idle accept", accept, 0);
      end
    end
  end

  task automatic put(logic [7:0] b, logic st);
    @(negedge clk); byte_valid = 1'b1; addr_start = st; rx_byte = b;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); byte_valid = 1'b0; addr_start = 1'b0; rx_byte = 8'h5A;
    end
  endtask

  task automatic send(logic [47:0] a, int gap);
    for (int i = 0; i < 6; i++) begin
      put(a[47-8*i -: 8], i == 0);
      if (gap > 0) idle(gap);
    end
    idle(4);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++; n_checks++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin : stim
    logic [47:0] lo_a, hi_a, other_a;
    logic found_lo, found_hi;
    found_lo = 0; found_hi = 0; lo_a = '0; hi_a = '0;
    for (int k = 0; k < 256; k++) begin
      logic [47:0] c = {40'h01_00_5E_00_00, 8'(k)};
      if (!found_lo && ref_idx(c) < 32)  begin lo_a = c; found_lo = 1; end
      if (!found_hi && ref_idx(c) >= 32) begin hi_a = c; found_hi = 1; end
    end
    other_a = 48'h33_33_00_00_00_01;

    repeat (3) @(negedge clk);
    chk("R9 reset valid", decision_valid, 0);
    chk("R9 reset accept", accept, 0);
    rst = 1'b0;
    sta_lo = 32'h02_11_22_33; sta_hi = 32'h44_55_BE_EF;
    idle(2);

    cur_tag = "R3"; send(lo_a, 0); send(other_a, 0);
    cur_tag = "R4"; send(48'hFFFF_FFFF_FFFF, 0);
    cur_tag = "R5"; send(48'h02_11_22_33_44_55, 0);
    send(48'h02_11_22_33_44_54, 0);
    send(48'h02_10_22_33_44_55, 0);
    sta_hi = 32'h44_55_00_00; send(48'h02_11_22_33_44_55, 0);

    cur_tag = "R2";
    hash_lo = 32'd1 << ref_idx(lo_a)[4:0]; hash_hi = '0; idle(2);
    send(lo_a, 0); send(hi_a, 0);
    hash_lo = '0; hash_hi = 32'd1 << ref_idx(hi_a)[4:0]; idle(2);
    send(hi_a, 0); send(lo_a, 0);
    hash_lo = 32'hFFFF_FFFF; hash_hi = 32'hFFFF_FFFF; idle(2);
    send(other_a, 0);
    cur_tag = "R4"; hash_lo = '0; hash_hi = '0; idle(2);
    send(48'hFFFF_FFFF_FFFF, 0);

    cur_tag = "R7"; hash_hi = 32'hFFFF_FFFF; idle(2);
    send(hi_a, 2);
    send(48'h02_11_22_33_44_55, 1);
    for (int i = 0; i < 6; i++) put(hi_a[47-8*i -: 8], i == 0);
    put(8'h01, 0); put(8'hFF, 0); put(8'h00, 0); idle(5);

    cur_tag = "R8";
    put(8'hFF, 1); put(8'hFF, 0); put(8'hFF, 0);
    send(48'h02_11_22_33_44_55, 0);
    put(8'h01, 1); idle(1); put(8'h00, 0);
    send(48'h02_11_22_33_44_56, 0);

    cur_tag = "R9";
    for (int i = 0; i < 4; i++) put(lo_a[47-8*i -: 8], i == 0);
    rst = 1'b1; idle(1);
    chk("R9 reset mid-frame", decision_valid, 0);
    idle(1); rst = 1'b0;
    put(8'h44, 0); put(8'h55, 0); idle(4);

    idle(4);
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule